// File: doc/BRIEF.md
# UART Receiver Mute and Wakeup Controller

This block sits behind a UART deserializer. It decides whether each received character is passed on, and it keeps a mute flag. While the flag is set the receiver stays silent. Characters arrive and are dropped, and no data-valid strobe is raised. This lets a node on a shared multi-drop line ignore traffic meant for other nodes.

Software may set or clear the flag at any time. Hardware clears it by one of two wakeup methods, picked by a select input. In idle-line wakeup, the flag drops when the line goes idle. In address wakeup, the flag drops when an address character carries this node's address. A mismatching address character sets the flag again. When software and hardware change the flag in the same cycle, hardware wins.

The deserializer is not part of this block. It supplies a character strobe with its data and an idle-line strobe.

Top module: `uart_mute_ctrl`

## Requirements
- R1: After reset, `muted` and `data_valid` are 0 and `data_out` is 0.
- R2: A pulse on `mute_wr` loads `mute_wdata` into `muted` on the next clock edge, where 1 means muted and 0 means active. This holds when no hardware event occurs in that cycle.
- R3: When `wake_sel` = 0 (idle-line wakeup) and `rx_en` = 1, an `idle_stb` pulse clears `muted` on the next edge.
- R4: An address character has bit DATA_W-1 of `char_data` equal to 1. Its low ADDR_W bits are compared with `node_addr`. When `wake_sel` = 1 and `rx_en` = 1, a matching address character clears `muted` and is delivered: `data_valid` = 1 and `data_out` holds the character, one cycle after the strobe.
- R5: When `wake_sel` = 1 and `rx_en` = 1, a mismatching address character sets `muted`, whatever state the flag was in. The character is not delivered.
- R6: While muted, a character that does not cause wakeup raises no `data_valid`. When `wake_sel` = 1, `idle_stb` has no effect on `muted`.
- R7: While active, each `char_stb` produces `data_valid` = 1 for one cycle on the following cycle, with `data_out` equal to the character.
- R8: With `rx_en` = 0, `char_stb` and `idle_stb` are ignored: no `data_valid`, and no hardware change to `muted`.
- R9: A hardware clear or set of `muted` in the same cycle as a `mute_wr` pulse takes priority over the software value.
- R10: When `wake_sel` = 0, characters with the top bit set are ordinary data. They are delivered when active and dropped when muted, with no address comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| mute_wr | input | 1 | Software write strobe for the mute flag |
| mute_wdata | input | 1 | Value written by software (1 = mute) |
| wake_sel | input | 1 | Wakeup method: 0 idle line, 1 address match |
| node_addr | input | ADDR_W | This node's address |
| char_stb | input | 1 | Received character strobe |
| char_data | input | DATA_W | Received character |
| idle_stb | input | 1 | Idle line detected strobe |
| muted | output | 1 | Current mute flag |
| data_valid | output | 1 | Delivered character strobe |
| data_out | output | DATA_W | Delivered character |

## Verification
The risky coincidence is a software write to the mute flag landing in the same cycle as a hardware wakeup or re-mute. Examples are `idle_stb` together with a write of 1, a matching address character with a write of 1, and a mismatching one with a write of 0. The bench drives these collisions on purpose and also lets them occur freely in a long pseudo-random phase. Every cycle, it compares the flag and the delivery strobe against a behavioural model in which hardware outranks software.

// File: rtl/uart_mute_ctrl.sv
module uart_mute_ctrl #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              mute_wr,
  input  logic              mute_wdata,
  input  logic              wake_sel,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic              char_stb,
  input  logic [DATA_W-1:0] char_data,
  input  logic              idle_stb,
  output logic              muted,
  output logic              data_valid,
  output logic [DATA_W-1:0] data_out
);
  localparam int TOP = DATA_W - 1;

  logic is_addr, addr_hit, idle_wake, addr_seen, deliver;

  assign is_addr   = char_data[TOP];
  assign addr_hit  = (char_data[ADDR_W-1:0] == node_addr);
  assign idle_wake = rx_en & ~wake_sel & idle_stb;
  assign addr_seen = rx_en & wake_sel & char_stb & is_addr;
  assign deliver   = rx_en & char_stb & ((wake_sel & is_addr) ? addr_hit : ~muted);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      muted      <= 1'b0;
      data_valid <= 1'b0;
      data_out   <= '0;
    end else begin
      if (idle_wake)      muted <= 1'b0;
      else if (addr_seen) muted <= ~addr_hit;
      else if (mute_wr)   muted <= mute_wdata;
      data_valid <= deliver;
      if (deliver) data_out <= char_data;
    end
  end
endmodule

module uart_mute_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              mute_wr,
  input logic              mute_wdata,
  input logic              wake_sel,
  input logic [ADDR_W-1:0] node_addr,
  input logic              char_stb,
  input logic [DATA_W-1:0] char_data,
  input logic              idle_stb,
  input logic              muted,
  input logic              data_valid,
  input logic [DATA_W-1:0] data_out
);
  logic adr_c, hit_c, hw_c;
  assign adr_c = rx_en & wake_sel & char_stb & char_data[DATA_W-1];
  assign hit_c = char_data[ADDR_W-1:0] == node_addr;
  assign hw_c  = adr_c | (rx_en & ~wake_sel & idle_stb);

  AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_wr && !hw_c) |=> (muted == $past(mute_wdata))); // R2
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !wake_sel && idle_stb) |=> !muted); // R3
  AST_ADDR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_c && hit_c) |=> (!muted && data_valid && data_out == $past(char_data))); // R4
  AST_ADDR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_c && !hit_c) |=> (muted && !data_valid)); // R5
  AST_MUTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && !adr_c) |=> !data_valid); // R6
  AST_ACTIVE_DELIVER: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && char_stb && !muted && !adr_c) |=> (data_valid && data_out == $past(char_data))); // R7
  AST_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !data_valid); // R8
  AST_RX_OFF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !mute_wr) |=> $stable(muted)); // R8
  AST_HW_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_wr && adr_c) |=> (muted == !$past(hit_c))); // R9
endmodule

bind uart_mute_ctrl uart_mute_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mute_wr(mute_wr), .mute_wdata(mute_wdata),
  .wake_sel(wake_sel), .node_addr(node_addr), .char_stb(char_stb), .char_data(char_data),
  .idle_stb(idle_stb), .muted(muted), .data_valid(data_valid), .data_out(data_out)
);

// File: tb/uart_mute_ctrl_tb_top.sv
module uart_mute_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic rx_en = 0, mute_wr = 0, mute_wdata = 0, wake_sel = 0, char_stb = 0, idle_stb = 0;
  logic [3:0] node_addr = 4'h5;
  logic [7:0] char_data = 0;
  logic muted, data_valid;
  logic [7:0] data_out;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_mute = 0, m_valid = 0;
  logic [7:0] m_data = 0;

  always #10 clk = ~clk;

  uart_mute_ctrl dut_i (.clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mute_wr(mute_wr),
    .mute_wdata(mute_wdata), .wake_sel(wake_sel), .node_addr(node_addr), .char_stb(char_stb),
    .char_data(char_data), .idle_stb(idle_stb), .muted(muted), .data_valid(data_valid),
    .data_out(data_out));

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit en, bit wr, bit wd, bit sel, bit ch, logic [7:0] d, bit idl);
    bit nm, nv, is_adr, hit;
    rx_en = en; mute_wr = wr; mute_wdata = wd; wake_sel = sel;
    char_stb = ch; char_data = d; idle_stb = idl;
    is_adr = d[7]; hit = (d[3:0] == node_addr);
    nm = m_mute;
    nv = 0;
    if (en && ch) begin
      if (sel && is_adr) nv = hit;
      else nv = !m_mute;
    end
    if (en && !sel && idl) nm = 0;
    else if (en && sel && ch && is_adr) nm = !hit;
    else if (wr) nm = wd;
    @(posedge clk);
    m_mute = nm; m_valid = nv;
    if (nv) m_data = d;
    @(negedge clk);
    check(tag, "muted", {7'd0, muted}, {7'd0, m_mute});
    check(tag, "data_valid", {7'd0, data_valid}, {7'd0, m_valid});
    if (m_valid) check(tag, "data_out", data_out, m_data);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "muted", {7'd0, muted}, 8'd0);
    check("R1", "data_valid", {7'd0, data_valid}, 8'd0);
    check("R1", "data_out", data_out, 8'd0);
    rst_n = 1;
    @(negedge clk);
    // active, idle mode
    step("R7", 1, 0, 0, 0, 1, 8'h12, 0);
    step("R7", 1, 0, 0, 0, 1, 8'h34, 0);
    step("R10", 1, 0, 0, 0, 1, 8'h85, 0);
    step("R10", 1, 0, 0, 0, 1, 8'h8A, 0);
    step("R2", 1, 1, 1, 0, 0, 8'h00, 0);
    step("R6", 1, 0, 0, 0, 1, 8'h21, 0);
    step("R10", 1, 0, 0, 0, 1, 8'h85, 0);
    step("R3", 1, 0, 0, 0, 0, 8'h00, 1);
    step("R7", 1, 0, 0, 0, 1, 8'h56, 0);
    step("R2", 1, 1, 1, 0, 0, 8'h00, 0);
    step("R2", 1, 1, 0, 0, 0, 8'h00, 0);
    step("R7", 1, 0, 0, 0, 1, 8'h57, 0);
    // address mode
    step("R2", 1, 1, 1, 1, 0, 8'h00, 0);
    step("R6", 1, 0, 0, 1, 1, 8'h33, 0);
    step("R6", 1, 0, 0, 1, 0, 8'h00, 1);
    step("R5", 1, 0, 0, 1, 1, 8'h8A, 0);
    step("R4", 1, 0, 0, 1, 1, 8'h85, 0);
    step("R7", 1, 0, 0, 1, 1, 8'h40, 0);
    step("R4", 1, 0, 0, 1, 1, 8'hF5, 0);
    step("R5", 1, 0, 0, 1, 1, 8'h87, 0);
    step("R6", 1, 0, 0, 1, 1, 8'h41, 0);
    // receiver disabled
    step("R8", 0, 0, 0, 1, 1, 8'h85, 0);
    step("R8", 0, 0, 0, 0, 0, 8'h00, 1);
    step("R8", 0, 0, 0, 0, 1, 8'h11, 0);
    step("R2", 0, 1, 0, 0, 0, 8'h00, 0);
    step("R8", 0, 0, 0, 1, 1, 8'h87, 0);
    step("R8", 0, 0, 0, 0, 1, 8'h22, 0);
    // hardware versus software in one cycle
    step("R2", 1, 1, 1, 0, 0, 8'h00, 0);
    step("R9", 1, 1, 1, 0, 0, 8'h00, 1);
    step("R9", 1, 1, 0, 1, 1, 8'h8C, 0);
    step("R9", 1, 1, 1, 1, 1, 8'h85, 0);
    step("R9", 1, 1, 1, 1, 1, 8'h95, 0);
    node_addr = 4'hC;
    step("R4", 1, 1, 1, 1, 1, 8'h9C, 0);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[31:28] == 0) node_addr = r[27:24];
      step("R9", r[0] | r[1], r[2] & r[3], r[4], r[5], r[6], {r[7], 3'b000, r[11:8]}, r[12] & r[13]);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule